// File: doc/BRIEF.md
# Composite Blanking Waveform Generator

This block builds one active-high composite blanking signal for a display timing path. It takes four inputs that are not tied to the system clock: horizontal sync, vertical sync, horizontal flyback and vertical flyback. It also takes a vertical sync pulse that an on-chip timer produces. Every input first passes through a two-stage synchronizer. Each flyback input is then brought to active-high by its own inversion bit.

A shaping stage offers several forms of vertical sync:
- the raw signal;
- a copy re-sampled on each horizontal sync rising edge;
- a copy whose falling edge is held back until the next horizontal sync rising edge;
- the held-back copy re-sampled on horizontal sync;
- the internal timer pulse.

A 3-bit select input picks one of these forms. The two normalized flyback signals and the chosen vertical sync are ORed together. An edge-sensed set/reset flop turns that combined level into the blanking output. A rising edge of the combined level sets the flop and a falling edge clears it.

Top module: `blank_gen`

## Requirements
- R1: A synchronous active-high `rst` clears the output, the synchronizers, the edge history and the shaping registers. While `rst` is high at a clock edge, `blank_out` is 0 after that edge, whatever the inputs are.
- R2: With `vsync_sel` equal to 0, 5, 6 or 7, the raw synchronized vertical sync is the chosen source. With both flybacks inactive, a rise of `vsync_in` shows on `blank_out` after exactly 3 rising clock edges: two synchronizer stages and the output flop.
- R3: With `vsync_sel` = 1, the source is a register that loads the synchronized vertical sync on each detected rising edge of synchronized horizontal sync, and holds its value otherwise.
- R4: With `vsync_sel` = 2, the source is set whenever the synchronized vertical sync is high. When vertical sync goes low, the source stays high until the next detected horizontal sync rising edge clears it.
- R5: With `vsync_sel` = 3, the source is the R4 signal loaded into a register on each detected horizontal sync rising edge.
- R6: With `vsync_sel` = 4, the source is the synchronized `int_vsync_in`.
- R7: When `hfly_inv` is 1, `hfly_in` is active-low. When `vfly_inv` is 1, `vfly_in` is active-low. When an inversion bit is 0, its input is active-high.
- R8: The combined level is the OR of the normalized horizontal flyback, the normalized vertical flyback and the chosen vertical sync. A single active term is enough to drive `blank_out` high.
- R9: A rising edge of the combined level sets `blank_out` on the next clock edge and a falling edge clears it. With no edge, `blank_out` holds its value. Set wins if both occur in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| vsync_sel | input | 3 | Vertical sync source select (0 raw, 1 re-timed, 2 fall-held, 3 both, 4 internal, 5-7 raw) |
| hfly_inv | input | 1 | Invert horizontal flyback before combining |
| vfly_inv | input | 1 | Invert vertical flyback before combining |
| hsync_in | input | 1 | Horizontal sync, asynchronous |
| vsync_in | input | 1 | Vertical sync, asynchronous |
| hfly_in | input | 1 | Horizontal flyback, asynchronous |
| vfly_in | input | 1 | Vertical flyback, asynchronous |
| int_vsync_in | input | 1 | Internally generated vertical sync |
| blank_out | output | 1 | Composite blanking, active high |

## Verification
A wrong re-timed or fall-held register shows on `blank_out` only while its source is selected and both flybacks are inactive. The error appears one clock after the combined level would have changed and lasts until the next horizontal sync rising edge repairs the register. A stale edge history shows as a missing or extra transition of `blank_out` within one cycle. The bench therefore runs long random stretches per select value with flybacks mostly idle and compares every cycle against a bench model.

// File: rtl/blank_pkg.sv
package blank_pkg;
  localparam int SEL_W = 3;
  localparam int NUM_ASYNC = 5;

  // bit positions inside the synchronized input vector
  localparam int IDX_HS = 0;
  localparam int IDX_VS = 1;
  localparam int IDX_HF = 2;
  localparam int IDX_VF = 3;
  localparam int IDX_IV = 4;

  typedef enum logic [SEL_W-1:0] {
    VS_RAW     = 3'd0,
    VS_RETIME  = 3'd1,
    VS_FALLMOD = 3'd2,
    VS_BOTH    = 3'd3,
    VS_INT     = 3'd4
  } vs_src_e;

  // choose the vertical sync form; unused codes fall back to raw
  function automatic logic pick_vsync(input logic [SEL_W-1:0] sel,
                                      input logic raw, input logic rt,
                                      input logic fm, input logic both,
                                      input logic intl);
    logic r;
    case (sel)
      VS_RETIME:  r = rt;
      VS_FALLMOD: r = fm;
      VS_BOTH:    r = both;
      VS_INT:     r = intl;
      default:    r = raw;
    endcase
    return r;
  endfunction

  function automatic logic normalize(input logic level, input logic inv);
    return level ^ inv;
  endfunction

  // {rise, fall} of a level given its previous value
  function automatic logic [1:0] edges(input logic cur, input logic prev);
    return {cur & ~prev, ~cur & prev};
  endfunction
endpackage

// File: rtl/blank_sync.sv
module blank_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= '0;
          else     stage_q[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= '0;
          else     stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/vsync_shaper.sv
module vsync_shaper
  import blank_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             hs,
  input  logic             vs,
  input  logic             iv,
  input  logic [SEL_W-1:0] sel,
  output logic             vs_chosen,
  output logic             hs_rise,
  output logic             rt_q,
  output logic             fm_q
);
  logic       hs_prev;
  logic       both_q;
  logic [1:0] hs_edges;

  assign hs_edges = edges(hs, hs_prev);
  assign hs_rise  = hs_edges[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_prev <= 1'b0;
      rt_q    <= 1'b0;
      fm_q    <= 1'b0;
      both_q  <= 1'b0;
    end else begin
      hs_prev <= hs;
      if (hs_rise) begin
        rt_q   <= vs;
        both_q <= fm_q;
      end
      if (vs)           fm_q <= 1'b1;
      else if (hs_rise) fm_q <= 1'b0;
    end
  end

  assign vs_chosen = pick_vsync(sel, vs, rt_q, fm_q, both_q, iv);
endmodule

// File: rtl/blank_flop.sv
module blank_flop
  import blank_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic comb,
  output logic blank,
  output logic rise,
  output logic fall
);
  logic       comb_prev;
  logic [1:0] e;

  assign e    = edges(comb, comb_prev);
  assign rise = e[1];
  assign fall = e[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      comb_prev <= 1'b0;
      blank     <= 1'b0;
    end else begin
      comb_prev <= comb;
      if (rise)      blank <= 1'b1;
      else if (fall) blank <= 1'b0;
    end
  end
endmodule

// File: rtl/blank_gen.sv
module blank_gen
  import blank_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] vsync_sel,
  input  logic             hfly_inv,
  input  logic             vfly_inv,
  input  logic             hsync_in,
  input  logic             vsync_in,
  input  logic             hfly_in,
  input  logic             vfly_in,
  input  logic             int_vsync_in,
  output logic             blank_out
);
  logic [NUM_ASYNC-1:0] raw_vec;
  logic [NUM_ASYNC-1:0] syn_vec;
  logic hs_s, vs_s;
  logic hf_n, vf_n;
  logic vs_pick, hs_rise, rt_q, fm_q;
  logic comb, comb_rise, comb_fall;

  always_comb begin
    raw_vec         = '0;
    raw_vec[IDX_HS] = hsync_in;
    raw_vec[IDX_VS] = vsync_in;
    raw_vec[IDX_HF] = hfly_in;
    raw_vec[IDX_VF] = vfly_in;
    raw_vec[IDX_IV] = int_vsync_in;
  end

  blank_sync #(.W(NUM_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_vec), .q(syn_vec)
  );

  assign hs_s = syn_vec[IDX_HS];
  assign vs_s = syn_vec[IDX_VS];
  assign hf_n = normalize(syn_vec[IDX_HF], hfly_inv);
  assign vf_n = normalize(syn_vec[IDX_VF], vfly_inv);

  vsync_shaper u_shape (
    .clk(clk), .rst(rst), .hs(hs_s), .vs(vs_s), .iv(syn_vec[IDX_IV]),
    .sel(vsync_sel), .vs_chosen(vs_pick), .hs_rise(hs_rise),
    .rt_q(rt_q), .fm_q(fm_q)
  );

  assign comb = hf_n | vf_n | vs_pick;

  blank_flop u_flop (
    .clk(clk), .rst(rst), .comb(comb),
    .blank(blank_out), .rise(comb_rise), .fall(comb_fall)
  );
endmodule

// File: rtl/blank_gen_chk.sv
module blank_gen_chk (
  input logic clk,
  input logic rst,
  input logic vs_s,
  input logic hs_rise,
  input logic rt_q,
  input logic fm_q,
  input logic comb,
  input logic comb_rise,
  input logic comb_fall,
  input logic blank_out
);
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> !blank_out);

  p_rt_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !hs_rise |=> $stable(rt_q));

  p_rt_load_r3: assert property (@(posedge clk) disable iff (rst)
    hs_rise |=> rt_q == $past(vs_s));

  p_fm_set_r4: assert property (@(posedge clk) disable iff (rst)
    vs_s |=> fm_q);

  p_fm_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (fm_q && !hs_rise) |=> fm_q);

  p_fm_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (!vs_s && hs_rise) |=> !fm_q);

  p_set_r9: assert property (@(posedge clk) disable iff (rst)
    comb_rise |=> blank_out);

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (comb_fall && !comb_rise) |=> !blank_out);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!comb_rise && !comb_fall) |=> $stable(blank_out));

  p_level_r8: assert property (@(posedge clk) disable iff (rst)
    comb |=> blank_out);
endmodule

bind blank_gen blank_gen_chk u_chk (
  .clk(clk), .rst(rst), .vs_s(vs_s), .hs_rise(hs_rise), .rt_q(rt_q),
  .fm_q(fm_q), .comb(comb), .comb_rise(comb_rise), .comb_fall(comb_fall),
  .blank_out(blank_out)
);

// File: tb/blank_gen_tb.sv
`timescale 1ns/1ps
module blank_gen_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] vsync_sel = 3'd0;
  logic hfly_inv = 1'b0, vfly_inv = 1'b0;
  logic hsync_in = 1'b0, vsync_in = 1'b0, hfly_in = 1'b0, vfly_in = 1'b0;
  logic int_vsync_in = 1'b0;
  logic blank_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  blank_gen u_dut (
    .clk(clk), .rst(rst), .vsync_sel(vsync_sel), .hfly_inv(hfly_inv),
    .vfly_inv(vfly_inv), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .hfly_in(hfly_in), .vfly_in(vfly_in), .int_vsync_in(int_vsync_in),
    .blank_out(blank_out)
  );

  // reference model, written from the requirements
  logic [4:0] m_s1 = '0, m_s2 = '0;
  logic m_hsp = 0, m_rt = 0, m_fm = 0, m_both = 0, m_cp = 0, m_blank = 0;
  logic m_hsr, m_pick, m_comb;

  function automatic logic ref_pick(input logic [2:0] s, input logic raw,
                                    input logic rt, input logic fm,
                                    input logic bo, input logic iv);
    if (s == 3'd1) return rt;
    if (s == 3'd2) return fm;
    if (s == 3'd3) return bo;
    if (s == 3'd4) return iv;
    return raw;
  endfunction

  function automatic string req_of(input logic [2:0] s);
    case (s)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R2";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = '0; m_s2 = '0; m_hsp = 0; m_rt = 0; m_fm = 0; m_both = 0;
      m_cp = 0; m_blank = 0;
    end else begin
      m_hsr  = m_s2[0] & ~m_hsp;
      m_pick = ref_pick(vsync_sel, m_s2[1], m_rt, m_fm, m_both, m_s2[4]);
      m_comb = (m_s2[2] ^ hfly_inv) | (m_s2[3] ^ vfly_inv) | m_pick;
      if (m_comb && !m_cp)      m_blank = 1'b1;
      else if (!m_comb && m_cp) m_blank = 1'b0;
      m_cp = m_comb;
      if (m_hsr) begin
        m_both = m_fm;
        m_rt   = m_s2[1];
      end
      if (m_s2[1])    m_fm = 1'b1;
      else if (m_hsr) m_fm = 1'b0;
      m_hsp = m_s2[0];
      m_s2  = m_s1;
      m_s1  = {int_vsync_in, vfly_in, hfly_in, vsync_in, hsync_in};
    end
  end

  task automatic check_val(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: blank_out=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // one clock edge, then compare against the model away from the edge
  task automatic step(input string req);
    @(posedge clk);
    @(negedge clk);
    check_val(blank_out, m_blank, req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int hs_per, hs_cnt;
    void'($urandom(32'd20240611));
    // R1: reset with every input active
    hsync_in = 1; vsync_in = 1; hfly_in = 1; vfly_in = 1; int_vsync_in = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check_val(blank_out, 1'b0, "R1");
    hsync_in = 0; vsync_in = 0; hfly_in = 0; vfly_in = 0; int_vsync_in = 0;
    rst = 0;
    idle(5);
    check_val(blank_out, 1'b0, "R1");

    // R2: select 5 behaves as raw; latency 3 edges
    vsync_sel = 3'd5;
    vsync_in = 1;
    step("R2"); check_val(blank_out, 1'b0, "R2");
    step("R2"); check_val(blank_out, 1'b0, "R2");
    step("R2"); check_val(blank_out, 1'b1, "R2");
    vsync_in = 0;
    idle(4);
    check_val(blank_out, 1'b0, "R2");

    // R7: inverted horizontal flyback held high means inactive
    hfly_inv = 1; hfly_in = 1;
    idle(5);
    check_val(blank_out, 1'b0, "R7");
    hfly_in = 0;
    idle(3);
    check_val(blank_out, 1'b1, "R7");
    hfly_in = 1; hfly_inv = 0;
    idle(4);
    check_val(blank_out, 1'b1, "R8");
    hfly_in = 0; vfly_inv = 1; vfly_in = 1;
    idle(4);
    check_val(blank_out, 1'b0, "R7");
    vfly_in = 0;
    idle(4);
    check_val(blank_out, 1'b1, "R8");
    vfly_in = 1; vfly_inv = 0;
    idle(20);
    check_val(blank_out, 1'b1, "R9");
    vfly_in = 0;
    idle(4);
    check_val(blank_out, 1'b0, "R9");

    // R4: fall of vertical sync held until a horizontal sync rise
    vsync_sel = 3'd2;
    vsync_in = 1; idle(4); vsync_in = 0;
    idle(12);
    check_val(blank_out, 1'b1, "R4");
    hsync_in = 1; idle(6);
    check_val(blank_out, 1'b0, "R4");
    hsync_in = 0; idle(3);

    // R6: internal source
    vsync_sel = 3'd4; int_vsync_in = 1; vsync_in = 0;
    idle(3);
    check_val(blank_out, 1'b1, "R6");
    int_vsync_in = 0; idle(3);
    check_val(blank_out, 1'b0, "R6");

    // random segments over all select values, compared per cycle
    for (int seg = 0; seg < 32; seg++) begin
      vsync_sel = 3'(seg % 8);
      hfly_inv = 1'($urandom_range(0, 1));
      vfly_inv = 1'($urandom_range(0, 1));
      hs_per = $urandom_range(5, 12);
      hs_cnt = 0;
      for (int c = 0; c < 400; c++) begin
        hs_cnt = (hs_cnt + 1) % hs_per;
        hsync_in = (hs_cnt < 2);
        if ($urandom_range(0, 29) == 0) vsync_in = ~vsync_in;
        if ($urandom_range(0, 39) == 0) int_vsync_in = ~int_vsync_in;
        hfly_in = ($urandom_range(0, 49) == 0) ? ~hfly_inv : hfly_inv;
        vfly_in = ($urandom_range(0, 59) == 0) ? ~vfly_inv : vfly_inv;
        step(req_of(vsync_sel));
      end
    end

    // R1: mid-run reset clears the output
    vsync_sel = 3'd0; vsync_in = 1; idle(4);
    rst = 1;
    step("R1");
    check_val(blank_out, 1'b0, "R1");
    rst = 0;
    idle(4);
    check_val(blank_out, 1'b1, "R2");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule